// File: doc/BRIEF.md
# Watchdog Timer with Paired Software Clear

This block is a watchdog for a small processor. A selectable tick source drives a prescaler, and the prescaler drives a time-out counter. When the counter wraps, the block raises a reset request and sets a sticky time-out flag. If the core is running normally, the request is a one-cycle full chip reset. If the core is halted in power-down, the request is a one-cycle wake reset, which only restarts the program counter and stack pointer.

Software keeps the watchdog quiet in one of two ways, chosen by a static configuration pin:

- **Single mode:** one clear strobe restarts the timer.
- **Paired mode:** two distinct clear strobes, half one and half two, must alternate. A half is accepted only when it differs from the last accepted half. A clear happens only when the opposite half arrives. Repeating the same half does nothing.

Halt entry and the active-low external reset also restart the timer. Both of them also forget which half was accepted last.

The tick sources are modelled as enables in the clock domain: a watchdog oscillator tick, a real-time oscillator tick, the clock divided by a parameter (four by default), or off.

Top module: `wdog_timer`

## Requirements
- R1: While `rstN` is low, asynchronously: the prescaler, counter, paired-clear tracker and clock divider hold zero, `toFlag` is 0 and both pulse outputs are 0.
- R2: `srcSel` picks the tick:
  - 0: `oscTick`.
  - 1: every SYS_DIV-th clock; the first tick is counted on clock edge SYS_DIV after `rstN` rises.
  - 2: `rtcTick`.
  - 3: no tick, and the counter holds its value.
- R3: A time-out happens on the 2^(PRE_W+CNT_W)-th counted tick after the last restart. The pulse is visible for one cycle after the edge that counts that tick. Prescaler and counter restart from zero after every time-out.
- R4: With `powerDown` low at the time-out edge, `chipRst` pulses for one cycle, `wakeRst` stays 0 and `toFlag` becomes 1.
- R5: With `powerDown` high at the time-out edge, `wakeRst` pulses for one cycle, `chipRst` stays 0 and `toFlag` becomes 1.
- R6: `toFlag` stays 1 through further time-outs. Only reset, halt entry or a successful software clear return it to 0.
- R7: A `haltEnter` strobe does four things:
  - clears prescaler, counter and `toFlag`;
  - resets the paired-clear tracker to "no half";
  - wins over a tick in the same cycle;
  - lets counting resume on the next tick after that edge.
- R8: With `pairMode` = 0, `clrSingle` restarts the timer and clears `toFlag`, with the same timing as halt. `clrHalf1` and `clrHalf2` have no effect.
- R9: With `pairMode` = 1:
  - From "no half", the first half is only recorded.
  - A half different from the recorded one restarts the timer, clears `toFlag` and becomes the recorded half.
  - A repeated half has no effect.
  - `clrSingle` has no effect.
  - Both halves in the same cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous external reset, active low |
| srcSel | input | 2 | Tick source: 0 osc, 1 clock/SYS_DIV, 2 rtc, 3 off |
| oscTick | input | 1 | Watchdog oscillator tick enable |
| rtcTick | input | 1 | Real-time oscillator tick enable |
| pairMode | input | 1 | 0 single clear, 1 paired clear |
| clrSingle | input | 1 | Single-mode clear strobe |
| clrHalf1 | input | 1 | Paired-mode first clear strobe |
| clrHalf2 | input | 1 | Paired-mode second clear strobe |
| haltEnter | input | 1 | Halt instruction strobe |
| powerDown | input | 1 | Core is in power-down |
| chipRst | output | 1 | One-cycle full chip reset request |
| wakeRst | output | 1 | One-cycle wake reset request |
| toFlag | output | 1 | Sticky time-out status |

## Verification
The assertions take three things for granted about the inputs:

- `pairMode` and `srcSel` are configuration and do not change while a strobe is in flight.
- Every strobe is exactly one clock wide and synchronous.
- `rstN` is held low for at least one edge.

The stimulus meets this as follows. It drives every strobe for a single cycle from a negative clock edge. It changes the configuration only between strobes. It asserts reset on a negative edge and holds it across several edges.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    SRC_OSC  = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_RTC  = 2'd2,
    SRC_OFF  = 2'd3
  } tickSrc_e;

  typedef enum logic [1:0] {
    HALF_NONE = 2'd0,
    HALF_ONE  = 2'd1,
    HALF_TWO  = 2'd2
  } clrHalf_e;

  // strobes from control to datapath
  typedef struct packed {
    logic swClear;
    logic haltClear;
  } wdCtl_t;

endpackage

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel
  import wdog_pkg::*;
#(
  parameter int SYS_DIV = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  tickSrc_e srcSel,
  input  logic     oscTick,
  input  logic     rtcTick,
  output logic     tick
);

  logic sysTick;

  generate
    if (SYS_DIV > 1) begin : gen_div
      localparam int DIV_W = $clog2(SYS_DIV);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SYS_DIV - 1);
      logic [DIV_W-1:0] divQ;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          divQ <= '0;
        end else if (divQ == DIV_LAST) begin
          divQ <= '0;
        end else begin
          divQ <= divQ + 1'b1;
        end
      end

      assign sysTick = (divQ == DIV_LAST);
    end else begin : gen_nodiv
      assign sysTick = 1'b1;
    end
  endgenerate

  always_comb begin
    unique case (srcSel)
      SRC_OSC: tick = oscTick;
      SRC_SYS: tick = sysTick;
      SRC_RTC: tick = rtcTick;
      default: tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   pairMode,
  input  logic   clrSingle,
  input  logic   clrHalf1,
  input  logic   clrHalf2,
  input  logic   haltEnter,
  output wdCtl_t ctl
);

  clrHalf_e halfQ;
  logic     oneOnly;
  logic     twoOnly;
  logic     pairHit;

  // simultaneous halves cancel each other
  assign oneOnly = clrHalf1 & ~clrHalf2;
  assign twoOnly = clrHalf2 & ~clrHalf1;
  assign pairHit = (oneOnly && halfQ == HALF_TWO) || (twoOnly && halfQ == HALF_ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfQ <= HALF_NONE;
    end else if (haltEnter) begin
      halfQ <= HALF_NONE;
    end else if (pairMode) begin
      if (oneOnly && halfQ != HALF_ONE) begin
        halfQ <= HALF_ONE;
      end else if (twoOnly && halfQ != HALF_TWO) begin
        halfQ <= HALF_TWO;
      end
    end
  end

  always_comb begin
    ctl.haltClear = haltEnter;
    ctl.swClear   = ~haltEnter & (pairMode ? pairHit : clrSingle);
  end

endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int CNT_W = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   tick,
  input  logic   powerDown,
  input  wdCtl_t ctl,
  output logic   chipRst,
  output logic   wakeRst,
  output logic   toFlag
);

  logic [PRE_W-1:0] preQ;
  logic [CNT_W-1:0] cntQ;
  logic             flagQ;
  logic             chipQ;
  logic             wakeQ;
  logic             preFull;
  logic             cntFull;
  logic             clrAny;
  logic             wrapNow;

  assign preFull = &preQ;
  assign cntFull = &cntQ;
  assign clrAny  = ctl.swClear | ctl.haltClear;
  assign wrapNow = tick & preFull & cntFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preQ  <= '0;
      cntQ  <= '0;
      flagQ <= 1'b0;
      chipQ <= 1'b0;
      wakeQ <= 1'b0;
    end else begin
      chipQ <= 1'b0;
      wakeQ <= 1'b0;
      if (clrAny) begin
        preQ  <= '0;
        cntQ  <= '0;
        flagQ <= 1'b0;
      end else if (tick) begin
        preQ <= preQ + 1'b1;
        if (preFull) begin
          cntQ <= cntQ + 1'b1;
        end
        if (wrapNow) begin
          flagQ <= 1'b1;
          chipQ <= ~powerDown;
          wakeQ <= powerDown;
        end
      end
    end
  end

  assign chipRst = chipQ;
  assign wakeRst = wakeQ;
  assign toFlag  = flagQ;

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int PRE_W   = 8,
  parameter int CNT_W   = 8,
  parameter int SYS_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] srcSel,
  input  logic       oscTick,
  input  logic       rtcTick,
  input  logic       pairMode,
  input  logic       clrSingle,
  input  logic       clrHalf1,
  input  logic       clrHalf2,
  input  logic       haltEnter,
  input  logic       powerDown,
  output logic       chipRst,
  output logic       wakeRst,
  output logic       toFlag
);

  logic   tick;
  wdCtl_t ctl;

  wdog_tick_sel #(.SYS_DIV(SYS_DIV)) tick_i (
    .clk     (clk),
    .rstN    (rstN),
    .srcSel  (tickSrc_e'(srcSel)),
    .oscTick (oscTick),
    .rtcTick (rtcTick),
    .tick    (tick)
  );

  wdog_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .pairMode  (pairMode),
    .clrSingle (clrSingle),
    .clrHalf1  (clrHalf1),
    .clrHalf2  (clrHalf2),
    .haltEnter (haltEnter),
    .ctl       (ctl)
  );

  wdog_datapath #(.PRE_W(PRE_W), .CNT_W(CNT_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .powerDown (powerDown),
    .ctl       (ctl),
    .chipRst   (chipRst),
    .wakeRst   (wakeRst),
    .toFlag    (toFlag)
  );

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] srcSel,
  input logic       pairMode,
  input logic       clrSingle,
  input logic       haltEnter,
  input logic       powerDown,
  input logic       chipRst,
  input logic       wakeRst,
  input logic       toFlag
);

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(chipRst && wakeRst)); // R4
  AST_CHIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) chipRst |=> !chipRst); // R4
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) wakeRst |=> !wakeRst); // R5
  AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN) (chipRst || wakeRst) |-> toFlag); // R6
  AST_PD_NO_CHIP: assert property (@(posedge clk) disable iff (!rstN) powerDown |=> !chipRst); // R5
  AST_RUN_NO_WAKE: assert property (@(posedge clk) disable iff (!rstN) !powerDown |=> !wakeRst); // R4
  AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (!rstN) haltEnter |=> !toFlag); // R7
  AST_SINGLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN) (!pairMode && clrSingle) |=> !toFlag); // R8
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN) (srcSel == 2'd3) |=> !(chipRst || wakeRst)); // R2

endmodule

bind wdog_timer wdog_timer_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .srcSel    (srcSel),
  .pairMode  (pairMode),
  .clrSingle (clrSingle),
  .haltEnter (haltEnter),
  .powerDown (powerDown),
  .chipRst   (chipRst),
  .wakeRst   (wakeRst),
  .toFlag    (toFlag)
);

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb_top;

  localparam int PRE_W   = 2;
  localparam int CNT_W   = 3;
  localparam int SYS_DIV = 4;
  localparam int NTICK   = 1 << (PRE_W + CNT_W);

  localparam int K_SINGLE = 0;
  localparam int K_ONE    = 1;
  localparam int K_TWO    = 2;
  localparam int K_BOTH   = 3;
  localparam int K_HALT   = 4;

  typedef struct {
    int    at;
    logic  isWake;
    string tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] srcSel;
  logic       oscTick, rtcTick, pairMode;
  logic       clrSingle, clrHalf1, clrHalf2, haltEnter, powerDown;
  logic       chipRst, wakeRst, toFlag;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  expItem_t expQ[$];
  expItem_t seen;

  wdog_timer #(.PRE_W(PRE_W), .CNT_W(CNT_W), .SYS_DIV(SYS_DIV)) dut_i (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .oscTick(oscTick), .rtcTick(rtcTick),
    .pairMode(pairMode), .clrSingle(clrSingle), .clrHalf1(clrHalf1), .clrHalf2(clrHalf2),
    .haltEnter(haltEnter), .powerDown(powerDown),
    .chipRst(chipRst), .wakeRst(wakeRst), .toFlag(toFlag)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(input int at, input logic isWake, input string tag);
    expItem_t e;
    e.at = at; e.isWake = isWake; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one-cycle strobe; c is the cycle count before the sampling edge
  task automatic hit(input int kind, output int c);
    @(negedge clk);
    c = cyc;
    case (kind)
      K_SINGLE: clrSingle = 1'b1;
      K_ONE:    clrHalf1 = 1'b1;
      K_TWO:    clrHalf2 = 1'b1;
      K_BOTH:   begin clrHalf1 = 1'b1; clrHalf2 = 1'b1; end
      default:  haltEnter = 1'b1;
    endcase
    @(negedge clk);
    clrSingle = 1'b0; clrHalf1 = 1'b0; clrHalf2 = 1'b0; haltEnter = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (chipRst || wakeRst) begin
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R3 unexpected pulse actual=cycle %0d expected=none", cyc);
      end else begin
        seen = expQ.pop_front();
        if (seen.at != cyc || seen.isWake != wakeRst || chipRst == wakeRst) begin
          bad++;
          $display("FAIL %s actual=cycle %0d wake=%0b chip=%0b expected=cycle %0d wake=%0b",
                   seen.tag, cyc, wakeRst, chipRst, seen.at, seen.isWake);
        end
      end
    end else if (expQ.size() > 0 && expQ[0].at < cyc) begin
      total++;
      bad++;
      seen = expQ.pop_front();
      $display("FAIL %s missed pulse actual=none expected=cycle %0d", seen.tag, seen.at);
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c;
    int d;
    rstN = 1'b0; srcSel = 2'd0; oscTick = 1'b1; rtcTick = 1'b0; pairMode = 1'b0;
    clrSingle = 1'b0; clrHalf1 = 1'b0; clrHalf2 = 1'b0; haltEnter = 1'b0; powerDown = 1'b0;
    idle(3);
    check(!toFlag && !chipRst && !wakeRst, "R1 reset state", {toFlag, chipRst, wakeRst}, 0);

    // R1/R3/R4: first time-out after release, then restart
    @(negedge clk);
    c = cyc;
    rstN = 1'b1;
    push(c + NTICK, 1'b0, "R3");
    push(c + 2 * NTICK, 1'b0, "R6");
    while (expQ.size() > 1) @(negedge clk);
    @(negedge clk);
    check(toFlag == 1'b1, "R4 flag set", toFlag, 1);
    drain();
    check(toFlag == 1'b1, "R6 flag sticky", toFlag, 1);

    // R8: single clears, repeated before expiry
    hit(K_SINGLE, c);
    check(toFlag == 1'b0, "R8 flag cleared", toFlag, 0);
    idle(20);
    hit(K_SINGLE, c);
    idle(20);
    hit(K_SINGLE, c);
    push(c + 1 + NTICK, 1'b0, "R8");
    idle(8);
    hit(K_ONE, d);
    idle(4);
    hit(K_TWO, d);
    drain();

    // R5: power-down wake reset
    powerDown = 1'b1;
    hit(K_SINGLE, c);
    push(c + 1 + NTICK, 1'b1, "R5");
    drain();
    check(toFlag == 1'b1, "R5 flag set", toFlag, 1);

    // R7: halt clears
    hit(K_HALT, c);
    check(toFlag == 1'b0, "R7 halt clears flag", toFlag, 0);
    push(c + 1 + NTICK, 1'b1, "R7");
    drain();
    powerDown = 1'b0;

    // R9: paired mode
    pairMode = 1'b1;
    hit(K_HALT, c);
    push(c + 1 + NTICK, 1'b0, "R9 first half only recorded");
    idle(4);
    hit(K_ONE, d);
    idle(4);
    hit(K_ONE, d);
    idle(4);
    hit(K_SINGLE, d);
    drain();
    check(toFlag == 1'b1, "R9 no clear from repeated half", toFlag, 1);
    hit(K_TWO, c);
    check(toFlag == 1'b0, "R9 opposite half clears", toFlag, 0);
    push(c + 1 + NTICK, 1'b0, "R9 repeat two ignored");
    idle(4);
    hit(K_TWO, d);
    idle(4);
    hit(K_BOTH, d);
    drain();
    hit(K_ONE, c);
    check(toFlag == 1'b0, "R9 one after two clears", toFlag, 0);
    push(c + 1 + NTICK, 1'b0, "R9");
    drain();
    // R7: halt forgets the recorded half
    hit(K_HALT, c);
    push(c + 1 + NTICK, 1'b0, "R7 tracker reset");
    idle(4);
    hit(K_TWO, d);
    drain();
    check(toFlag == 1'b1, "R7 half two after halt only recorded", toFlag, 1);
    pairMode = 1'b0;

    // R2: disabled source holds the count
    hit(K_SINGLE, c);
    srcSel = 2'd3;
    idle(100);
    d = cyc;
    srcSel = 2'd0;
    push(d + NTICK, 1'b0, "R2 off then osc");
    drain();

    // R2: rtc source
    oscTick = 1'b0;
    rtcTick = 1'b1;
    srcSel = 2'd2;
    hit(K_SINGLE, c);
    push(c + 1 + NTICK, 1'b0, "R2 rtc");
    drain();

    // R1 async reset, then R2 divided clock
    rstN = 1'b0;
    #1;
    check(toFlag == 1'b0, "R1 async flag clear", toFlag, 0);
    srcSel = 2'd1;
    idle(2);
    @(negedge clk);
    c = cyc;
    rstN = 1'b1;
    push(c + SYS_DIV * NTICK, 1'b0, "R2 divided clock");
    drain();
    check(toFlag == 1'b1, "R2 flag after divided time-out", toFlag, 1);

    check(expQ.size() == 0, "R3 queue empty", expQ.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule